// File: doc/BRIEF.md
# Mode-Selected Address / General-Purpose Port

This block controls one 8-bit pin group that can carry either the high byte of the external address (address bits 15 down to 8) or general-purpose I/O. The role of each pin comes from two things. The first is a 3-bit operating-mode input, which sets the class of the whole port. The second is a per-pin direction bit written by software. In the address class every pin drives its address bit. In the shared class the direction bit chooses between driving the address bit and acting as a plain input. In the general-purpose class the direction bit chooses between driving the data register and acting as an input.

Software reaches three registers through one select field: data, direction and pull-up. Writes are registered. Reads are combinational from the current state and the sampled pin levels. Pin n always corresponds to address bit 8+n. The block produces a per-pin output value, output enable and pull-up enable for the pad ring.

Top module: `addr_gpio_port`

## Requirements
- R1: After synchronous reset the data, direction and pull-up registers are all zero. In mode 7 every output enable and every pull-up enable is therefore 0.
- R2: In modes 0, 1, 2, 3 and 4, every output enable is 1 and `pin_out_o` equals `addr_hi_i`, whatever the direction register holds.
- R3: In modes 5 and 6, a pin whose direction bit is 1 is enabled and drives `addr_hi_i[n]`. A pin whose direction bit is 0 is not enabled and presents 0 on `pin_out_o[n]`.
- R4: In mode 7, a pin whose direction bit is 1 is enabled and drives data register bit n. A pin whose direction bit is 0 is not enabled and presents 0 on `pin_out_o[n]`.
- R5: `pin_pu_o[n]` is 1 only when pull-up register bit n is 1 and the pin is not output-enabled.
- R6: With select 0 (data), the read value per pin is the data register bit if the pin is a mode-7 output, and `pin_i[n]` otherwise.
- R7: With select 1 (direction), the read value is all ones.
- R8: A write (`wr_en_i` high, select 0 = data, 1 = direction, 2 = pull-up) updates the register at the clock edge that ends the strobe cycle. Outputs and reads in the strobe cycle still show the old value.
- R9: With select 2 (pull-up), the read value is the pull-up register. Select 3 reads zero, and a write to select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode, static after reset |
| addr_hi_i | input | 8 | Address bits 15..8 from the bus controller |
| reg_sel_i | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 reserved |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Read data for the selected register |
| pin_i | input | 8 | Sampled pin levels |
| pin_out_o | output | 8 | Per-pin output value |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
A register write and a read can fall in the same cycle, and so can a write and the pin drive that depends on it. The bench holds the write strobe on the data register in mode 7 with all pins set as outputs. Before the clock edge it samples both `rd_data_o` and `pin_out_o`, and both must still show the old byte. After the edge both must show the new byte. A direction write in shared mode is judged the same way: the output enables change only after the edge.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;

    localparam int PORT_W = 8;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CLS_ADDR   = 2'd0,
        CLS_SHARED = 2'd1,
        CLS_GPIO   = 2'd2
    } mode_cls_e;

    typedef enum logic [1:0] {
        ROLE_ADDR = 2'd0,
        ROLE_GPO  = 2'd1,
        ROLE_IN   = 2'd2
    } pin_role_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
        logic rd;
    } pin_drive_t;

    function automatic mode_cls_e classify(input logic [MODE_W-1:0] mode);
        case (mode)
            3'd5, 3'd6: return CLS_SHARED;
            3'd7:       return CLS_GPIO;
            default:    return CLS_ADDR;
        endcase
    endfunction

    function automatic pin_role_e pick_role(input mode_cls_e cls, input logic dir);
        case (cls)
            CLS_SHARED: return dir ? ROLE_ADDR : ROLE_IN;
            CLS_GPIO:   return dir ? ROLE_GPO  : ROLE_IN;
            default:    return ROLE_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/port_regs.sv
module port_regs
    import port_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  reg_sel_e     wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] data_q_o,
    output logic [W-1:0] dir_q_o,
    output logic [W-1:0] pull_q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q_o <= '0;
            dir_q_o  <= '0;
            pull_q_o <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_DATA: data_q_o <= wr_data_i;
                SEL_DIR:  dir_q_o  <= wr_data_i;
                SEL_PULL: pull_q_o <= wr_data_i;
                default:  ;
            endcase
        end
    end

    // R1: reset clears every register
    a_r1_regs_clear: assert property (@(posedge clk)
        rst |=> (data_q_o == '0 && dir_q_o == '0 && pull_q_o == '0));

    // R8: data write lands on the following edge
    a_r8_data_next: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_DATA) |=> data_q_o == $past(wr_data_i));

    // R8: direction write lands on the following edge
    a_r8_dir_next: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_DIR) |=> dir_q_o == $past(wr_data_i));

    // R9: reserved select leaves all registers unchanged
    a_r9_rsvd_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_RSVD) |=>
            ($stable(data_q_o) && $stable(dir_q_o) && $stable(pull_q_o)));

endmodule

// File: rtl/port_pin_cell.sv
module port_pin_cell
    import port_mux_pkg::*;
(
    input  mode_cls_e  cls_i,
    input  logic       dir_i,
    input  logic       data_i,
    input  logic       pull_i,
    input  logic       addr_i,
    input  logic       pin_i,
    output pin_drive_t drv_o
);

    pin_role_e role;

    always_comb begin
        role      = pick_role(cls_i, dir_i);
        drv_o     = '0;
        drv_o.rd  = pin_i;
        case (role)
            ROLE_ADDR: begin
                drv_o.out = addr_i;
                drv_o.oe  = 1'b1;
            end
            ROLE_GPO: begin
                drv_o.out = data_i;
                drv_o.oe  = 1'b1;
                drv_o.rd  = data_i;
            end
            default: begin
                drv_o.pu  = pull_i;
            end
        endcase
    end

endmodule

// File: rtl/port_readback.sv
module port_readback
    import port_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  reg_sel_e     sel_i,
    input  logic [W-1:0] port_rd_i,
    input  logic [W-1:0] pull_q_i,
    output logic [W-1:0] rd_data_o
);

    always_comb begin
        case (sel_i)
            SEL_DATA: rd_data_o = port_rd_i;
            SEL_DIR:  rd_data_o = '1;
            SEL_PULL: rd_data_o = pull_q_i;
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
    import port_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [W-1:0]        addr_hi_i,
    input  logic [SEL_W-1:0]    reg_sel_i,
    input  logic                wr_en_i,
    input  logic [W-1:0]        wr_data_i,
    output logic [W-1:0]        rd_data_o,
    input  logic [W-1:0]        pin_i,
    output logic [W-1:0]        pin_out_o,
    output logic [W-1:0]        pin_oe_o,
    output logic [W-1:0]        pin_pu_o
);

    reg_sel_e   sel;
    mode_cls_e  cls;
    logic [W-1:0] data_q, dir_q, pull_q, port_rd;

    assign sel = reg_sel_e'(reg_sel_i);
    assign cls = classify(mode_i);

    port_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (sel),
        .wr_data_i(wr_data_i),
        .data_q_o (data_q),
        .dir_q_o  (dir_q),
        .pull_q_o (pull_q)
    );

    for (genvar n = 0; n < W; n++) begin : g_pin
        pin_drive_t drv;
        port_pin_cell u_cell (
            .cls_i (cls),
            .dir_i (dir_q[n]),
            .data_i(data_q[n]),
            .pull_i(pull_q[n]),
            .addr_i(addr_hi_i[n]),
            .pin_i (pin_i[n]),
            .drv_o (drv)
        );
        assign pin_out_o[n] = drv.out;
        assign pin_oe_o[n]  = drv.oe;
        assign pin_pu_o[n]  = drv.pu;
        assign port_rd[n]   = drv.rd;
    end

    port_readback #(.W(W)) u_rb (
        .sel_i    (sel),
        .port_rd_i(port_rd),
        .pull_q_i (pull_q),
        .rd_data_o(rd_data_o)
    );

    // R2: address modes drive the whole address byte
    a_r2_addr_forced: assert property (@(posedge clk) disable iff (rst)
        (mode_i <= 3'd4) |-> (pin_oe_o == '1 && pin_out_o == addr_hi_i));

    // R3: shared modes follow direction for address output
    a_r3_shared_dir: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd5 || mode_i == 3'd6) |->
            (pin_oe_o == dir_q && pin_out_o == (addr_hi_i & dir_q)));

    // R4: general-purpose mode drives the data register on outputs
    a_r4_gpio_dir: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd7) |-> (pin_oe_o == dir_q && pin_out_o == (data_q & dir_q)));

    // R5: pull-up never coincides with a driven pin
    a_r5_pu_no_drive: assert property (@(posedge clk) disable iff (rst)
        (pin_pu_o & pin_oe_o) == '0);

    // R6: data read in mode 7 mixes register bits and pin levels
    a_r6_read_mix: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DATA && mode_i == 3'd7) |->
            rd_data_o == ((data_q & dir_q) | (pin_i & ~dir_q)));

endmodule

// File: tb/test_addr_gpio_port.sv
`timescale 1ns/1ps
module test_addr_gpio_port;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode;
    logic [7:0] addr_hi;
    logic [1:0] reg_sel;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] pin_in;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    addr_gpio_port i_addr_gpio_port (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode),
        .addr_hi_i(addr_hi),
        .reg_sel_i(reg_sel),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .rd_data_o(rd_data),
        .pin_i    (pin_in),
        .pin_out_o(pin_out),
        .pin_oe_o (pin_oe),
        .pin_pu_o (pin_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [7:0] exp);
        reg_sel = sel;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset;
        mode = 3'd7; pin_in = 8'hA5;
        @(negedge clk);
        chk("R1 oe after reset", pin_oe, 8'h00);
        chk("R1 pu after reset", pin_pu, 8'h00);
        chk("R1 out after reset", pin_out, 8'h00);
        rd_chk("R1 pull reg after reset", 2'd2, 8'h00);
        rd_chk("R6 data read all inputs", 2'd0, 8'hA5);
        rd_chk("R7 dir reads ones", 2'd1, 8'hFF);
    endtask

    task automatic t_addr_modes;
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'hFF);
        for (int m = 0; m <= 4; m++) begin
            mode = 3'(m); addr_hi = 8'h3C ^ 8'(m * 17);
            @(negedge clk);
            chk($sformatf("R2 oe mode %0d", m), pin_oe, 8'hFF);
            chk($sformatf("R2 out mode %0d", m), pin_out, 8'h3C ^ 8'(m * 17));
            chk($sformatf("R5 pu mode %0d", m), pin_pu, 8'h00);
        end
    endtask

    task automatic t_shared_modes;
        wr(2'd1, 8'hF0);
        addr_hi = 8'h96; pin_in = 8'h5C;
        for (int m = 5; m <= 6; m++) begin
            mode = 3'(m);
            @(negedge clk);
            chk($sformatf("R3 oe mode %0d", m), pin_oe, 8'hF0);
            chk($sformatf("R3 out mode %0d", m), pin_out, 8'h90);
            chk($sformatf("R5 pu mode %0d", m), pin_pu, 8'h0F);
            rd_chk($sformatf("R6 read mode %0d", m), 2'd0, 8'h5C);
        end
        // direction write in the same cycle as sampling: enables change after edge
        @(negedge clk);
        reg_sel = 2'd1; wr_data = 8'h3C; wr_en = 1'b1;
        #0.5;
        chk("R8 oe before edge", pin_oe, 8'hF0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 oe after edge", pin_oe, 8'h3C);
    endtask

    task automatic t_gpio;
        mode = 3'd7;
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'hCC);
        wr(2'd2, 8'hFF);
        pin_in = 8'h33;
        @(negedge clk);
        chk("R4 oe gpio", pin_oe, 8'hCC);
        chk("R4 out gpio", pin_out, 8'h48);
        chk("R5 pu gpio", pin_pu, 8'h33);
        rd_chk("R6 read gpio mix", 2'd0, 8'h7B);
        rd_chk("R7 dir reads ones gpio", 2'd1, 8'hFF);
    endtask

    task automatic t_same_cycle;
        mode = 3'd7;
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h00);
        @(negedge clk);
        reg_sel = 2'd0; wr_data = 8'hE7; wr_en = 1'b1;
        #0.5;
        chk("R8 out before edge", pin_out, 8'h00);
        chk("R8 read before edge", rd_data, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 out after edge", pin_out, 8'hE7);
        chk("R8 read after edge", rd_data, 8'hE7);
    endtask

    task automatic t_reserved;
        mode = 3'd7;
        wr(2'd2, 8'h81);
        rd_chk("R9 pull readback", 2'd2, 8'h81);
        wr(2'd3, 8'h00);
        rd_chk("R9 reserved reads zero", 2'd3, 8'h00);
        rd_chk("R9 pull unchanged", 2'd2, 8'h81);
        rd_chk("R9 data unchanged", 2'd0, 8'hE7);
        chk("R9 oe unchanged", pin_oe, 8'hFF);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 3'd7; addr_hi = 8'h00; reg_sel = 2'd0;
        wr_en = 1'b0; wr_data = 8'h00; pin_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_addr_modes;
        t_shared_modes;
        t_gpio;
        t_same_cycle;
        t_reserved;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule